// File: doc/BRIEF.md
# Power Mode and Clock-Divide Controller

This block sequences the operating modes of a small microcontroller core. A configuration word, loaded through a write strobe, holds a 3-bit divide select, a standby-enable bit, a low-speed-on bit and a watchdog-select bit. The divide select sets the CPU clock-enable rate: every system clock cycle, or one cycle in 2, 4, 8, 16 or 32. The enable is a one-cycle strobe taken from a free-running 5-bit prescaler, so the clock tree itself is never gated. Peripherals that are not bus masters get an enable that does not depend on the divide setting.

A new divide select is held pending and becomes active only on a cycle where the bus-cycle-end strobe is high. This applies to a change back to all zeros as well. A sleep request enters sleep or software standby, depending on the configuration bits. Interrupts bring the core back to full or divided speed, according to the pending divide select. Three inputs take priority over all of this: the reset pin, a watchdog overflow and the hardware-standby pin.

All pins are plain level or strobe signals sampled on the rising clock edge. There is no data stream, and so no valid/ready handshake or back-pressure.

Top module: `pwrmode_ctl`

## Requirements
- R1: While `res_n` is low or `wdt_ovf` is high (and `hwstby_n` is high), the next mode is 0 (reset). All configuration bits clear to zero and both enables are 0 in mode 0. From mode 0 with `res_n` high and `wdt_ovf` low, the next mode is 1.
- R2: In mode 1 (high-speed) the active divide select is zero and `cpu_ce` is 1 on every cycle.
- R3: In mode 2 (medium-speed) the active divide select d is nonzero. `cpu_ce` is 1 exactly when the low n bits of the prescaler are all ones, where n = min(d,5), so it pulses once every 2^n cycles. Selects 6 and 7 behave as 5.
- R4: `per_ce` is 1 in modes 1, 2 and 3 regardless of the divide select. It is 0 in modes 0, 4 and 5.
- R5: `cfg_we` loads the pending configuration on the next edge. In mode 1 or 2, with no sleep entry, a cycle with `bus_end` high copies the pending select into the active select, and the next mode is 1 if that select is zero and 2 otherwise. Without `bus_end` the active select and the mode do not change. When the active select changes, the prescaler restarts at zero, so the first pulse falls 2^n cycles after that edge (counting the cycle after the edge as cycle 1).
- R6: In mode 1 or 2, `sleep_req` with standby bit 0 and low-speed bit 0 gives mode 3 (sleep) on the next cycle. In sleep `cpu_ce` is 0.
- R7: In sleep, `irq_any` or `irq_ext` copies the pending select into the active select. The next mode is 1 if that select is zero and 2 otherwise.
- R8: `sleep_req` with standby bit 1, low-speed bit 0 and watchdog-select bit 0 gives mode 4 (software standby). A `sleep_req` with low-speed bit 1, or with standby bit 1 and watchdog-select bit 1, is ignored.
- R9: Software standby is left only on `irq_ext`, which takes the same return path as R7. `irq_any` alone leaves the mode at 4.
- R10: `hwstby_n` low gives mode 5 on the next cycle from any mode, ahead of reset and watchdog, and clears the configuration. When it returns high, the next mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| res_n | input | 1 | Reset pin, active low, sampled synchronously |
| hwstby_n | input | 1 | Hardware-standby pin, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| cfg_we | input | 1 | Load strobe for the configuration word |
| cfg_div | input | 3 | Divide select: 0 full rate, d = 1..5 gives rate /2^d |
| cfg_stby | input | 1 | Standby-enable bit |
| cfg_lson | input | 1 | Low-speed-on bit |
| cfg_wsel | input | 1 | Watchdog-select bit |
| bus_end | input | 1 | High in the last cycle of a bus cycle |
| sleep_req | input | 1 | Sleep request strobe |
| irq_any | input | 1 | Any interrupt pending |
| irq_ext | input | 1 | External interrupt pending |
| mode | output | 3 | 0 reset, 1 high, 2 medium, 3 sleep, 4 software standby, 5 hardware standby |
| cpu_ce | output | 1 | Bus-master clock enable |
| per_ce | output | 1 | Peripheral clock enable |

## Verification
On every cycle, the assertions check these properties:
- hardware standby and reset/watchdog take hold on the next cycle;
- software standby holds until an external interrupt;
- sleep is only entered right after a request;
- the active divide select stays stable between applied bus-cycle ends;
- high-speed mode always has a zero active select.

Some behaviour can only be shown by the bench's scenarios, which compare against a cycle model:
- the exact spacing and phase of `cpu_ce` pulses after a prescaler restart;
- a pending select being ignored until `bus_end`;
- the return target after a wake;
- sleep requests that are ignored for some configurations.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DIV_W = 3;
  localparam int PSC_W = 5;

  typedef enum logic [2:0] {
    M_RESET  = 3'd0,
    M_HIGH   = 3'd1,
    M_MED    = 3'd2,
    M_SLEEP  = 3'd3,
    M_SWSTBY = 3'd4,
    M_HWSTBY = 3'd5
  } pmc_mode_e;
endpackage

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             stby_i,
  input  logic             lson_i,
  input  logic             wsel_i,
  input  logic             apply_i,
  output logic [DIV_W-1:0] div_pend_o,
  output logic [DIV_W-1:0] div_act_o,
  output logic             stby_o,
  output logic             lson_o,
  output logic             wsel_o,
  output logic             restart_o
);
  logic [DIV_W-1:0] pend_q, act_q;
  logic             stby_q, lson_q, wsel_q;

  always_ff @(posedge clk) begin
    if (clr_i) begin
      pend_q <= '0;
      act_q  <= '0;
      stby_q <= 1'b0;
      lson_q <= 1'b0;
      wsel_q <= 1'b0;
    end else begin
      if (we_i) begin
        pend_q <= div_i;
        stby_q <= stby_i;
        lson_q <= lson_i;
        wsel_q <= wsel_i;
      end
      if (apply_i) act_q <= pend_q;
    end
  end

  // prescaler restarts only when the active ratio really changes
  assign restart_o  = apply_i && (pend_q != act_q);
  assign div_pend_o = pend_q;
  assign div_act_o  = act_q;
  assign stby_o     = stby_q;
  assign lson_o     = lson_q;
  assign wsel_o     = wsel_q;

  a_r5_act_stable: assert property (@(posedge clk) disable iff (clr_i)
    !apply_i |=> $stable(act_q));
endmodule

// File: rtl/pmc_prescaler.sv
module pmc_prescaler #(
  parameter int DIV_W = 3,
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (restart_i) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // bit i of the mask is set when the ratio exponent exceeds i;
  // selects above PSC_W saturate to the full prescaler width
  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign mask[i] = (int'(div_i) > i);
  end

  assign tick_o = ((cnt_q & mask) == mask);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             res_n,
  input  logic             hwstby_n,
  input  logic             wdt_ovf,
  input  logic             sleep_req,
  input  logic             irq_any,
  input  logic             irq_ext,
  input  logic             bus_end,
  input  logic             stby_i,
  input  logic             lson_i,
  input  logic             wsel_i,
  input  logic [DIV_W-1:0] div_pend_i,
  output pmc_mode_e        mode_o,
  output logic             apply_o,
  output logic             clr_o
);
  pmc_mode_e mode_q, mode_d;
  pmc_mode_e run_target;
  logic      go_sleep, go_swstby;

  assign run_target = (div_pend_i == '0) ? M_HIGH : M_MED;
  assign go_sleep   = sleep_req && !lson_i && !stby_i;
  assign go_swstby  = sleep_req && !lson_i && stby_i && !wsel_i;

  always_comb begin
    mode_d  = mode_q;
    apply_o = 1'b0;
    clr_o   = 1'b0;
    if (!hwstby_n) begin
      mode_d = M_HWSTBY;
      clr_o  = 1'b1;
    end else if (!res_n || wdt_ovf) begin
      mode_d = M_RESET;
      clr_o  = 1'b1;
    end else begin
      unique case (mode_q)
        M_RESET:  mode_d = M_HIGH;
        M_HWSTBY: mode_d = M_RESET;
        M_HIGH, M_MED: begin
          if (go_sleep)       mode_d = M_SLEEP;
          else if (go_swstby) mode_d = M_SWSTBY;
          else if (bus_end) begin
            apply_o = 1'b1;
            mode_d  = run_target;
          end
        end
        M_SLEEP: begin
          if (irq_any || irq_ext) begin
            apply_o = 1'b1;
            mode_d  = run_target;
          end
        end
        M_SWSTBY: begin
          if (irq_ext) begin
            apply_o = 1'b1;
            mode_d  = run_target;
          end
        end
        default: mode_d = M_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) mode_q <= mode_d;

  assign mode_o = mode_q;

  a_r10_hwstby_wins: assert property (@(posedge clk) disable iff (!res_n)
    !hwstby_n |=> mode_q == M_HWSTBY);
  a_r1_wdt_reset: assert property (@(posedge clk) disable iff (!res_n)
    (hwstby_n && wdt_ovf) |=> mode_q == M_RESET);
  a_r9_swstby_hold: assert property (@(posedge clk) disable iff (!res_n)
    (mode_q == M_SWSTBY && hwstby_n && !wdt_ovf && !irq_ext) |=> mode_q == M_SWSTBY);
  a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!res_n)
    (mode_q != M_SLEEP && mode_d == M_SLEEP) |-> sleep_req);
endmodule

// File: rtl/pwrmode_ctl.sv
module pwrmode_ctl
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             res_n,
  input  logic             hwstby_n,
  input  logic             wdt_ovf,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_stby,
  input  logic             cfg_lson,
  input  logic             cfg_wsel,
  input  logic             bus_end,
  input  logic             sleep_req,
  input  logic             irq_any,
  input  logic             irq_ext,
  output logic [2:0]       mode,
  output logic             cpu_ce,
  output logic             per_ce
);
  pmc_mode_e        mode_s;
  logic             apply_s, clr_s, restart_s, tick_s;
  logic [DIV_W-1:0] div_pend_s, div_act_s;
  logic             stby_s, lson_s, wsel_s;

  pmc_mode_fsm #(.DIV_W(DIV_W)) u_fsm (
    .clk(clk), .res_n(res_n), .hwstby_n(hwstby_n), .wdt_ovf(wdt_ovf),
    .sleep_req(sleep_req), .irq_any(irq_any), .irq_ext(irq_ext),
    .bus_end(bus_end), .stby_i(stby_s), .lson_i(lson_s), .wsel_i(wsel_s),
    .div_pend_i(div_pend_s), .mode_o(mode_s), .apply_o(apply_s), .clr_o(clr_s)
  );

  pmc_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .clr_i(clr_s), .we_i(cfg_we), .div_i(cfg_div),
    .stby_i(cfg_stby), .lson_i(cfg_lson), .wsel_i(cfg_wsel),
    .apply_i(apply_s), .div_pend_o(div_pend_s), .div_act_o(div_act_s),
    .stby_o(stby_s), .lson_o(lson_s), .wsel_o(wsel_s), .restart_o(restart_s)
  );

  pmc_prescaler #(.DIV_W(DIV_W), .PSC_W(PSC_W)) u_psc (
    .clk(clk), .restart_i(restart_s || clr_s), .div_i(div_act_s), .tick_o(tick_s)
  );

  assign mode   = mode_s;
  assign cpu_ce = (mode_s == M_HIGH) || ((mode_s == M_MED) && tick_s);
  assign per_ce = (mode_s == M_HIGH) || (mode_s == M_MED) || (mode_s == M_SLEEP);

  a_r2_high_zero_div: assert property (@(posedge clk) disable iff (!res_n)
    mode_s == M_HIGH |-> div_act_s == '0);
  a_r3_med_nonzero_div: assert property (@(posedge clk) disable iff (!res_n)
    mode_s == M_MED |-> div_act_s != '0);
endmodule

// File: tb/pwrmode_ctl_test.sv
`timescale 1ns/1ps
module pwrmode_ctl_test;
  logic clk = 1'b0;
  logic res_n = 1'b0, hwstby_n = 1'b1, wdt_ovf = 1'b0;
  logic cfg_we = 1'b0, cfg_stby = 1'b0, cfg_lson = 1'b0, cfg_wsel = 1'b0;
  logic [2:0] cfg_div = 3'd0;
  logic bus_end = 1'b0, sleep_req = 1'b0, irq_any = 1'b0, irq_ext = 1'b0;
  logic [2:0] mode;
  logic cpu_ce, per_ce;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int m_mode = 0, m_pend = 0, m_act = 0, m_cnt = 0;
  bit m_stby = 0, m_lson = 0, m_wsel = 0;

  always #2.5 clk = ~clk;

  pwrmode_ctl uut (
    .clk(clk), .res_n(res_n), .hwstby_n(hwstby_n), .wdt_ovf(wdt_ovf),
    .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_stby(cfg_stby), .cfg_lson(cfg_lson),
    .cfg_wsel(cfg_wsel), .bus_end(bus_end), .sleep_req(sleep_req),
    .irq_any(irq_any), .irq_ext(irq_ext), .mode(mode), .cpu_ce(cpu_ce), .per_ce(per_ce)
  );

  function automatic int run_of(int d);
    return (d == 0) ? 1 : 2;
  endfunction

  function automatic bit exp_cpu();
    int n = (m_act > 5) ? 5 : m_act;
    int msk = (1 << n) - 1;
    if (m_mode == 1) return 1'b1;
    if (m_mode == 2) return ((m_cnt & msk) == msk);
    return 1'b0;
  endfunction

  function automatic bit exp_per();
    return (m_mode == 1 || m_mode == 2 || m_mode == 3);
  endfunction

  task automatic model_step();
    int nm = m_mode;
    bit apply = 0, clr = 0;
    if (!hwstby_n) begin nm = 5; clr = 1; end
    else if (!res_n || wdt_ovf) begin nm = 0; clr = 1; end
    else begin
      case (m_mode)
        0: nm = 1;
        5: nm = 0;
        1, 2: begin
          if (sleep_req && !m_lson && !m_stby) nm = 3;
          else if (sleep_req && !m_lson && m_stby && !m_wsel) nm = 4;
          else if (bus_end) begin apply = 1; nm = run_of(m_pend); end
        end
        3: if (irq_any || irq_ext) begin apply = 1; nm = run_of(m_pend); end
        4: if (irq_ext) begin apply = 1; nm = run_of(m_pend); end
        default: nm = 0;
      endcase
    end
    if (clr) begin
      m_pend = 0; m_act = 0; m_stby = 0; m_lson = 0; m_wsel = 0; m_cnt = 0;
    end else begin
      bit rs = apply && (m_pend != m_act);
      if (apply) m_act = m_pend;
      if (cfg_we) begin
        m_pend = cfg_div; m_stby = cfg_stby; m_lson = cfg_lson; m_wsel = cfg_wsel;
      end
      m_cnt = rs ? 0 : ((m_cnt + 1) & 31);
    end
    m_mode = nm;
  endtask

  function automatic string tag_of(int md);
    case (md)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R6";
      4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    wdt_ovf = 0; cfg_we = 0; bus_end = 0; sleep_req = 0; irq_any = 0; irq_ext = 0;
  endtask

  // one clock: inputs already driven at negedge; step model; check at next negedge
  task automatic cyc(string tag);
    string t;
    @(posedge clk);
    model_step();
    @(negedge clk);
    t = (tag == "") ? tag_of(m_mode) : tag;
    check(t, "mode", int'(mode), m_mode);
    check(t, "cpu_ce", int'(cpu_ce), int'(exp_cpu()));
    check((tag == "") ? "R4" : t, "per_ce", int'(per_ce), int'(exp_per()));
    idle();
  endtask

  task automatic wr(int d, bit s, bit l, bit w);
    cfg_we = 1; cfg_div = 3'(d); cfg_stby = s; cfg_lson = l; cfg_wsel = w;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    @(negedge clk);
    // R1: reset held
    res_n = 0;
    repeat (4) cyc("R1");
    res_n = 1;
    cyc("R1");                         // leaves reset into mode 1
    repeat (3) cyc("R2");
    // R5: pending divide ignored until bus_end
    wr(2, 0, 0, 0);
    cyc("R5");
    repeat (4) cyc("R5");
    bus_end = 1;
    cyc("R5");
    repeat (12) cyc("R3");
    // R3: select 7 saturates to /32
    wr(7, 0, 0, 0);
    cyc("R3");
    bus_end = 1;
    cyc("R5");
    repeat (70) cyc("R3");
    // R6 / R4 / R7: sleep, per_ce kept, wake to pending select
    sleep_req = 1;
    cyc("R6");
    repeat (3) cyc("R4");
    wr(0, 0, 0, 0);
    cyc("R7");
    irq_any = 1;
    cyc("R7");
    repeat (3) cyc("R2");
    // R8 / R9: software standby, irq_any ignored, irq_ext wakes
    wr(3, 1, 0, 0);
    cyc("R8");
    sleep_req = 1;
    cyc("R8");
    irq_any = 1;
    cyc("R9");
    cyc("R9");
    irq_ext = 1;
    cyc("R9");
    repeat (10) cyc("R3");
    // R8: ignored sleep requests
    wr(3, 1, 0, 1);
    cyc("R8");
    sleep_req = 1;
    cyc("R8");
    wr(3, 0, 1, 0);
    cyc("R8");
    sleep_req = 1;
    cyc("R8");
    // R1: watchdog overflow
    wdt_ovf = 1;
    cyc("R1");
    cyc("R1");
    // R10: hardware standby beats reset
    hwstby_n = 0; res_n = 0;
    cyc("R10");
    res_n = 1;
    cyc("R10");
    hwstby_n = 1;
    cyc("R10");
    cyc("R1");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      res_n    = ($urandom_range(0, 299) != 0);
      hwstby_n = ($urandom_range(0, 399) != 0);
      wdt_ovf  = ($urandom_range(0, 349) == 0);
      if ($urandom_range(0, 15) == 0)
        wr($urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 3) == 0,
           $urandom_range(0, 2) == 0);
      bus_end   = ($urandom_range(0, 2) == 0);
      sleep_req = ($urandom_range(0, 24) == 0);
      irq_any   = ($urandom_range(0, 9) == 0);
      irq_ext   = ($urandom_range(0, 19) == 0);
      cyc("");
      res_n = 1; hwstby_n = 1;
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule